// File: doc/BRIEF.md
# Strap-Banked Three-Wire Configuration Slave

This block is the register slave behind a three-wire serial configuration port. The port has an active-high frame enable, a serial clock and one shared data line. The data line reaches the block as a separate input, output and output-enable, and the pad is outside. The block keeps one control byte and three 8-bit gain codes. From them it drives the decoded settings that the analog front end uses: power state, wavelength channel, amplifier gain mode and the gain code of the chosen channel.

Each frame has 16 serial clocks. The first eight bits are a mode bit followed by a 7-bit address, and the last eight bits are data. Both halves are sent most significant bit first. A pre-decoded three-level strap chooses the address page that the slave answers on, so several slaves can share the same wires. All three pins are oversampled by the system clock through two-flop synchronizers. Every SCLK high level and low level must therefore last at least five system clocks. There is no back-pressure: the host sets the pace, and the slave never stalls a frame.

Top module: `tw_cfg_slave`

## Requirements
- R1: After reset the control byte is 01h and all three gain codes are FFh. The outputs then show sleep, channel BD (code 0), gain mode High2 (code 0) and gain code FFh, and `sdio_oe` is low.
- R2: A write frame has bit 15 (the first bit sent) at 0. Bits 14..8 are the address and bits 7..0 the data, and each bit is taken on a rising SCLK edge. The register updates only after the 16th rising edge.
- R3: The strap selects the page matched by address bits 6..4. `strap_i` 00 selects page 0 (00h-0Fh), 01 selects page 1 (10h-1Fh), and 10 or 11 selects page 7 (70h-7Fh). Address bits 3..0 choose the register: 0 is control, and 1, 2 and 3 are the BD, DVD and CD gain codes.
- R4: A read frame has bit 15 at 1. The slave leaves `sdio_oe` low during the eight address clocks. After each falling edge that follows rising edges 8 to 15, it drives the data bits D7 to D0 in order. It releases `sdio_oe` when the frame ends.
- R5: A read to an address outside the selected page keeps `sdio_oe` low for the whole frame. A write to such an address changes nothing.
- R6: Offsets 4 to 13 accept writes with no effect and read as 00h.
- R7: Offsets 14 and 15 read as 00h at all times, including after a write to them.
- R8: A frame in which the enable drops before the 16th rising edge is discarded and updates no register.
- R9: `pwr_on_o` is high only when control bits 7..6 are 11.
- R10: Control bits 3..2 select the channel: 00 or 01 gives BD (code 0), 10 gives DVD (code 1) and 11 gives CD (code 2). `gain_code_o` shows the gain register of that channel.
- R11: The gain mode is decoded from control bit 0 and bits 5..4. When bit 0 is 1, bits 5..4 of 00 or 01 give High2 (code 0) and 10 or 11 give High1 (code 1). When bit 0 is 0, 00 or 01 give Middle2 (code 2), 10 gives Middle1 (code 3) and 11 gives Low (code 4).
- R12: Control bit 1 is not stored and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_i | input | 1 | Frame enable, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, output side |
| sdio_oe | output | 1 | Output enable for the data line |
| strap_i | input | 2 | Pre-decoded page strap: 00 low, 01 high, 1x open |
| pwr_on_o | output | 1 | Front end powered on |
| chan_o | output | 2 | Channel: 0 BD, 1 DVD, 2 CD |
| gmode_o | output | 3 | Gain mode: 0 High2, 1 High1, 2 Middle2, 3 Middle1, 4 Low |
| gain_code_o | output | 8 | Gain code of the selected channel |

## Verification
The bench sweeps every strap code and all 16 offsets of the own page, and reads the other pages. A slave that matched too few address bits, or that ignored the strap, would drive the line on a foreign read or would let foreign writes change its gains. The bench writes all 256 control values and compares each decoded output with the arithmetic model. This finds a swapped field or a wrong alias of the channel code or the gain-mode code. Frames cut off at several points show whether a design commits partial data. Sampling the data line before every rising edge finds a slave that drives during the address phase or that is one bit out of step.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = 4;
  localparam int PAGE_W = ADDR_W - 1 - OFF_W;
  localparam int N_GAIN = 3;

  localparam logic [DATA_W-1:0] CTRL_RST  = 8'h01;
  localparam logic [DATA_W-1:0] GAIN_RST  = 8'hFF;
  localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hFD;

  localparam logic [1:0] CH_BD  = 2'd0;
  localparam logic [1:0] CH_DVD = 2'd1;
  localparam logic [1:0] CH_CD  = 2'd2;

  localparam logic [2:0] GM_HIGH2 = 3'd0;
  localparam logic [2:0] GM_HIGH1 = 3'd1;
  localparam logic [2:0] GM_MID2  = 3'd2;
  localparam logic [2:0] GM_MID1  = 3'd3;
  localparam logic [2:0] GM_LOW   = 3'd4;

  function automatic logic [PAGE_W-1:0] tw_page_of(input logic [1:0] strap);
    case (strap)
      2'b00:   return PAGE_W'(0);
      2'b01:   return PAGE_W'(1);
      default: return PAGE_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_cfg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int FRAME_BITS = AW + DW,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sen_s_i,
  input  logic             sclk_s_i,
  input  logic             sdio_s_i,
  input  logic [DW-1:0]    rd_data_i,
  input  logic             rd_hit_i,
  output logic [AW-2:0]    look_addr_o,
  output logic [AW-1:0]    frame_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             wr_stb_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             sdio_o,
  output logic             sdio_oe_o
);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(AW - 1);
  localparam logic [CNT_W-1:0] FIRST_DAT = CNT_W'(AW);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DONE      = CNT_W'(FRAME_BITS);

  logic             sclk_prev;
  logic             sclk_rise, sclk_fall;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    addr_sh, addr_next;
  logic [DW-1:0]    data_sh, rd_sh;
  logic             is_rd, rd_live, oe_q, dout_q, stb_q;

  assign sclk_rise = sclk_s_i & ~sclk_prev;
  assign sclk_fall = ~sclk_s_i & sclk_prev;
  assign addr_next = {addr_sh[AW-2:0], sdio_s_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      addr_sh <= '0;
      data_sh <= '0;
      rd_sh   <= '0;
      is_rd   <= 1'b0;
      rd_live <= 1'b0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (!sen_s_i) begin
        cnt     <= '0;
        is_rd   <= 1'b0;
        rd_live <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        if (sclk_rise && cnt < DONE) begin
          cnt <= cnt + 1'b1;
          if (cnt < FIRST_DAT) begin
            addr_sh <= addr_next;
            if (cnt == LAST_ADDR) begin
              is_rd   <= addr_next[AW-1];
              rd_live <= addr_next[AW-1] & rd_hit_i;
              rd_sh   <= rd_data_i;
            end
          end else begin
            data_sh <= {data_sh[DW-2:0], sdio_s_i};
            if (cnt == LAST_BIT && !is_rd) stb_q <= 1'b1;
          end
        end
        if (sclk_fall && rd_live) begin
          if (cnt >= FIRST_DAT && cnt < DONE) begin
            oe_q   <= 1'b1;
            dout_q <= rd_sh[DW-1];
            rd_sh  <= {rd_sh[DW-2:0], 1'b0};
          end else if (cnt == DONE) begin
            oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign look_addr_o  = addr_next[AW-2:0];
  assign frame_addr_o = addr_sh;
  assign wr_data_o    = data_sh;
  assign wr_stb_o     = stb_q;
  assign bit_cnt_o    = cnt;
  assign sdio_o       = dout_q;
  assign sdio_oe_o    = oe_q;
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_cfg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    strap_i,
  input  logic [ADDR_W-2:0]             look_addr_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_hit_o,
  input  logic                          wr_stb_i,
  input  logic [ADDR_W-2:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [DATA_W-1:0]             ctrl_o,
  output logic [N_GAIN-1:0][DATA_W-1:0] gain_o
);
  logic [PAGE_W-1:0]              page;
  logic [OFF_W-1:0]               look_off, wr_off;
  logic                           wr_hit;
  logic [DATA_W-1:0]              ctrl_q;
  logic [N_GAIN-1:0][DATA_W-1:0]  gain_q;

  assign page     = tw_page_of(strap_i);
  assign look_off = look_addr_i[OFF_W-1:0];
  assign wr_off   = wr_addr_i[OFF_W-1:0];
  assign rd_hit_o = (look_addr_i[ADDR_W-2:OFF_W] == page);
  assign wr_hit   = wr_stb_i && (wr_addr_i[ADDR_W-2:OFF_W] == page);

  always_comb begin
    rd_data_o = '0;
    if (look_off == '0) rd_data_o = ctrl_q;
    for (int g = 0; g < N_GAIN; g++) begin
      if (look_off == OFF_W'(g + 1)) rd_data_o = gain_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      gain_q <= {N_GAIN{GAIN_RST}};
    end else if (wr_hit) begin
      if (wr_off == '0) ctrl_q <= wr_data_i & CTRL_KEEP;
      for (int g = 0; g < N_GAIN; g++) begin
        if (wr_off == OFF_W'(g + 1)) gain_q[g] <= wr_data_i;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign gain_o = gain_q;
endmodule

// File: rtl/tw_ctrl_decode.sv
module tw_ctrl_decode
  import tw_cfg_pkg::*;
(
  input  logic [1:0]                    pwr_f_i,
  input  logic [1:0]                    ig1_f_i,
  input  logic [1:0]                    ch_f_i,
  input  logic                          ig2_f_i,
  input  logic [N_GAIN-1:0][DATA_W-1:0] gain_i,
  output logic                          pwr_on_o,
  output logic [1:0]                    chan_o,
  output logic [2:0]                    gmode_o,
  output logic [DATA_W-1:0]             gain_code_o
);
  always_comb begin
    pwr_on_o = &pwr_f_i;

    if (!ch_f_i[1])     chan_o = CH_BD;
    else if (!ch_f_i[0]) chan_o = CH_DVD;
    else                chan_o = CH_CD;

    if (ig2_f_i) begin
      gmode_o = ig1_f_i[1] ? GM_HIGH1 : GM_HIGH2;
    end else begin
      case (ig1_f_i)
        2'b11:   gmode_o = GM_LOW;
        2'b10:   gmode_o = GM_MID1;
        default: gmode_o = GM_MID2;
      endcase
    end

    case (chan_o)
      CH_DVD:  gain_code_o = gain_i[1];
      CH_CD:   gain_code_o = gain_i[2];
      default: gain_code_o = gain_i[0];
    endcase
  end
endmodule

// File: rtl/tw_cfg_slave.sv
module tw_cfg_slave
  import tw_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(ADDR_W + DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  input  logic [1:0]        strap_i,
  output logic              pwr_on_o,
  output logic [1:0]        chan_o,
  output logic [2:0]        gmode_o,
  output logic [DATA_W-1:0] gain_code_o
);
  logic [2:0]                    pin_s;
  logic                          sen_s, sclk_s, sdio_s;
  logic [DATA_W-1:0]             rd_data, wr_data, ctrl_q;
  logic                          rd_hit, wr_stb;
  logic [ADDR_W-2:0]             look_addr;
  logic [ADDR_W-1:0]             frame_addr;
  logic [CNT_W-1:0]              frame_cnt;
  logic [N_GAIN-1:0][DATA_W-1:0] gain_q;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sdio_i, sclk_i, sen_i}),
    .q_o   (pin_s)
  );

  assign sen_s  = pin_s[0];
  assign sclk_s = pin_s[1];
  assign sdio_s = pin_s[2];

  tw_frame u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .sen_s_i      (sen_s),
    .sclk_s_i     (sclk_s),
    .sdio_s_i     (sdio_s),
    .rd_data_i    (rd_data),
    .rd_hit_i     (rd_hit),
    .look_addr_o  (look_addr),
    .frame_addr_o (frame_addr),
    .wr_data_o    (wr_data),
    .wr_stb_o     (wr_stb),
    .bit_cnt_o    (frame_cnt),
    .sdio_o       (sdio_o),
    .sdio_oe_o    (sdio_oe)
  );

  tw_reg_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (strap_i),
    .look_addr_i (look_addr),
    .rd_data_o   (rd_data),
    .rd_hit_o    (rd_hit),
    .wr_stb_i    (wr_stb),
    .wr_addr_i   (frame_addr[ADDR_W-2:0]),
    .wr_data_i   (wr_data),
    .ctrl_o      (ctrl_q),
    .gain_o      (gain_q)
  );

  tw_ctrl_decode u_dec (
    .pwr_f_i     (ctrl_q[7:6]),
    .ig1_f_i     (ctrl_q[5:4]),
    .ch_f_i      (ctrl_q[3:2]),
    .ig2_f_i     (ctrl_q[0]),
    .gain_i      (gain_q),
    .pwr_on_o    (pwr_on_o),
    .chan_o      (chan_o),
    .gmode_o     (gmode_o),
    .gain_code_o (gain_code_o)
  );
endmodule

// File: rtl/tw_cfg_checker.sv
module tw_cfg_checker
  import tw_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sen_s,
  input logic              sdio_oe,
  input logic [4:0]        frame_cnt,
  input logic [ADDR_W-1:0] frame_addr,
  input logic [1:0]        strap_i,
  input logic              wr_stb,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] gain_code_o,
  input logic [2:0]        gmode_o
);
  AST_OE_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> frame_cnt >= 5'd8); // R4
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_s |=> !sdio_oe); // R4
  AST_OE_OWN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (frame_addr[ADDR_W-1] && frame_addr[ADDR_W-2:OFF_W] == tw_page_of(strap_i))); // R5
  AST_CTRL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(wr_stb)); // R2
  AST_GAIN_CODE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code_o != $past(gain_code_o)) |-> $past(wr_stb)); // R10
  AST_WR_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> frame_cnt == 5'd16); // R8
  AST_GMODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    gmode_o <= GM_LOW); // R11
  AST_CTRL_BIT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] == 1'b0); // R12
endmodule

bind tw_cfg_slave tw_cfg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sen_s       (sen_s),
  .sdio_oe     (sdio_oe),
  .frame_cnt   (frame_cnt),
  .frame_addr  (frame_addr),
  .strap_i     (strap_i),
  .wr_stb      (wr_stb),
  .ctrl_q      (ctrl_q),
  .gain_code_o (gain_code_o),
  .gmode_o     (gmode_o)
);

// File: tb/tw_cfg_slave_bench.sv
module tw_cfg_slave_bench;
  localparam int CLK_P = 10;
  localparam int HALF  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen = 1'b0, sclk = 1'b0, sdio_in = 1'b0;
  logic [1:0] strap = 2'b00;
  logic sdio_o, sdio_oe, pwr_on;
  logic [1:0] chan;
  logic [2:0] gmode;
  logic [7:0] gain_code;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] m_ctrl;
  logic [7:0] m_gain [3];

  always #(CLK_P/2) clk = ~clk;

  tw_cfg_slave u_tw_cfg_slave (
    .clk(clk), .rst_n(rst_n), .sen_i(sen), .sclk_i(sclk), .sdio_i(sdio_in),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .strap_i(strap), .pwr_on_o(pwr_on),
    .chan_o(chan), .gmode_o(gmode), .gain_code_o(gain_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic rd, input logic [6:0] a, input logic [7:0] wd,
                           input int nbits, output logic [7:0] rv, output int n_oe,
                           output int n_early);
    logic [15:0] word;
    word = {rd, a, wd};
    rv = '0; n_oe = 0; n_early = 0;
    @(negedge clk); sen = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdio_in = (rd && i >= 8) ? 1'b0 : word[15-i];
      repeat (HALF) @(negedge clk);
      if (sdio_oe) begin
        if (i < 8) n_early++;
        else begin n_oe++; rv[15-i] = sdio_o; end
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    sen = 1'b0; sdio_in = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  function automatic logic [2:0] page_of(input logic [1:0] s);
    return (s == 2'b00) ? 3'd0 : (s == 2'b01) ? 3'd1 : 3'd7;
  endfunction

  function automatic logic [7:0] exp_rd(input int off);
    if (off == 0) return m_ctrl;
    if (off >= 1 && off <= 3) return m_gain[off-1];
    return 8'h00;
  endfunction

  function automatic logic [1:0] exp_chan(input logic [7:0] c);
    return !c[3] ? 2'd0 : (c[2] ? 2'd2 : 2'd1);
  endfunction

  function automatic logic [2:0] exp_gmode(input logic [7:0] c);
    if (c[0]) return c[5] ? 3'd1 : 3'd0;
    if (c[5:4] == 2'b11) return 3'd4;
    if (c[5:4] == 2'b10) return 3'd3;
    return 3'd2;
  endfunction

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rv; int no, ne;
    run_frame(1'b0, a, d, 16, rv, no, ne);
    chk("R2 no drive on write", 32'(no + ne), 32'd0);
  endtask

  task automatic rd_own(input logic [2:0] pg, input int off, input string req);
    logic [7:0] rv; int no, ne;
    run_frame(1'b1, {pg, 4'(off)}, 8'h00, 16, rv, no, ne);
    chk("R4 quiet address phase", 32'(ne), 32'd0);
    chk("R4 eight data clocks driven", 32'(no), 32'd8);
    chk(req, 32'(rv), 32'(exp_rd(off)));
    chk("R4 released after frame", 32'(sdio_oe), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog all act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rv; int no, ne;
    m_ctrl = 8'h01; m_gain[0] = 8'hFF; m_gain[1] = 8'hFF; m_gain[2] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 pwr", 32'(pwr_on), 32'd0);
    chk("R1 chan", 32'(chan), 32'd0);
    chk("R1 gmode", 32'(gmode), 32'd0);
    chk("R1 gain code", 32'(gain_code), 32'hFF);
    chk("R1 oe", 32'(sdio_oe), 32'd0);
    for (int o = 0; o < 4; o++) rd_own(3'd0, o, "R1 reset readback");

    // R3 R6 R7 R5: sweep every strap code
    for (int s = 0; s < 4; s++) begin
      logic [2:0] pg;
      strap = 2'(s);
      pg = page_of(2'(s));
      for (int o = 0; o < 16; o++) begin
        logic [7:0] v;
        v = 8'((o * 37 + s * 11 + 8'h5A) ^ (o << 4));
        wr({pg, 4'(o)}, v);
        if (o == 0) m_ctrl = v & 8'hFD;
        else if (o <= 3) m_gain[o-1] = v;
      end
      for (int o = 0; o < 16; o++)
        rd_own(pg, o, (o < 4) ? "R3 own page readback" : (o < 14) ? "R6 reserved zero" : "R7 test zero");
      for (int f = 0; f < 4; f++) begin
        logic [2:0] fp;
        fp = (f == 0) ? 3'd0 : (f == 1) ? 3'd1 : (f == 2) ? 3'd7 : 3'd3;
        if (fp != pg) begin
          for (int o = 0; o < 4; o++) begin
            run_frame(1'b1, {fp, 4'(o)}, 8'h00, 16, rv, no, ne);
            chk("R5 foreign read stays hi-z", 32'(no + ne), 32'd0);
          end
          wr({fp, 4'd2}, 8'h3C);
          wr({fp, 4'd0}, 8'hC3);
        end
      end
      for (int o = 0; o < 4; o++) rd_own(pg, o, "R5 foreign write ignored");
    end

    // R9 R10 R11 R12: full control sweep
    strap = 2'b00;
    wr(7'h01, 8'h11); m_gain[0] = 8'h11;
    wr(7'h02, 8'h22); m_gain[1] = 8'h22;
    wr(7'h03, 8'h33); m_gain[2] = 8'h33;
    for (int c = 0; c < 256; c++) begin
      wr(7'h00, 8'(c));
      m_ctrl = 8'(c) & 8'hFD;
      chk("R9 power decode", 32'(pwr_on), 32'(c[7:6] == 2'b11));
      chk("R10 channel decode", 32'(chan), 32'(exp_chan(8'(c))));
      chk("R10 active gain code", 32'(gain_code), 32'(m_gain[exp_chan(8'(c))]));
      chk("R11 gain mode decode", 32'(gmode), 32'(exp_gmode(8'(c))));
      if (c % 32 == 3) rd_own(3'd0, 0, "R12 bit1 reads zero");
    end

    // R8: truncated frames
    for (int n = 1; n < 16; n += 4) begin
      run_frame(1'b0, 7'h01, 8'hA5, n, rv, no, ne);
      run_frame(1'b0, 7'h00, 8'hC0, 15, rv, no, ne);
      rd_own(3'd0, 1, "R8 truncated write dropped");
      rd_own(3'd0, 0, "R8 truncated control dropped");
    end
    run_frame(1'b1, 7'h02, 8'h00, 11, rv, no, ne);
    chk("R8 oe released after cut read", 32'(sdio_oe), 32'd0);
    wr(7'h02, 8'h5E); m_gain[1] = 8'h5E;
    rd_own(3'd0, 2, "R8 full frame after cut read");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule